// File: doc/BRIEF.md
# Error-Checking Flit Input Port

This block is the receiving side of one port of an on-chip network switch or network adapter when error control runs link by link. Each cycle at most one coded flit arrives: 32 payload bits protected by six Hamming check bits and one overall parity bit. The port decodes the word, judges it against the error policy chosen by a 2-bit mode input, and writes it into an eight-entry buffer only when the verdict is clean, the buffer has room and the switch has granted the output port the flit is heading to. Check bits are stripped before storage. The switch drains the buffer through a head-of-queue interface with a pop input.

The four policies are: no error control at all (raw payload stored), correction only (single-bit errors repaired, everything accepted), detection with resend (any detected error refused), and a hybrid that repairs single-bit errors and refuses only the ones it cannot repair. Any flit that the port refuses, whatever the reason, raises a one-cycle NACK toward the sender on the following cycle. After that, the port drops every incoming flit without comment until a flit marked as a resend arrives, so the stored order always matches the sender's order.

Top module: `hop_ecc_inport`

## Requirements
- R1: While reset is held, and in the first cycle after it, `nack` is 0 and `head_valid` is 0.
- R2: With `cfg_mode` = 0 (no error control), an accepted flit stores bits [31:0] of `flit_code` unchanged, whatever the check bits hold, and no error causes a NACK.
- R3: With `cfg_mode` = 1 (correct only), a single-bit error anywhere in the 39-bit word is repaired before storage, a double-bit error is stored as received, and no code error causes a NACK.
- R4: With `cfg_mode` = 2 (detect and resend), a flit with a single- or double-bit error is refused and `nack` is 1 in the next cycle; an error-free flit is accepted.
- R5: With `cfg_mode` = 3 (hybrid), a single-bit error (including one in the overall parity bit 38) is repaired and the flit accepted; a double-bit error is refused with a NACK in the next cycle.
- R6: When eight flits are stored, an arriving flit is neither decoded nor stored, is refused with a NACK, and the buffer never holds more than eight.
- R7: A flit arriving while `route_grant` is 0 is refused with a NACK in the next cycle.
- R8: After any refusal, flits with `flit_retry` = 0 are dropped with no NACK and no storage; the next flit with `flit_retry` = 1 is judged normally and ends the dropping if accepted.
- R9: `head_data` is the oldest stored payload while `head_valid` is 1; `head_pop` removes it at the clock edge; a write and a pop may occur at the same edge.
- R10: `nack` is a single-cycle pulse that is 1 only in the cycle right after a refused flit.
- R11: Code layout: payload in bits [31:0]; payload bits are assigned in increasing order to the Hamming positions 3,5,6,7,9,... (positions that are not powers of two); check bit 32+k is the XOR of the payload bits whose position has bit k set (k = 0..5); bit 38 makes the XOR of all 39 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Error policy: 0 none, 1 correct, 2 detect and resend, 3 hybrid |
| flit_valid | input | 1 | A coded flit is present this cycle |
| flit_retry | input | 1 | The present flit is a resend after a NACK |
| flit_code | input | 39 | Coded flit (layout in R11) |
| route_grant | input | 1 | Switch permits the flit's target output port |
| nack | output | 1 | Resend request for the flit of the previous cycle |
| head_valid | output | 1 | Buffer holds at least one payload |
| head_data | output | 32 | Oldest stored payload |
| head_pop | input | 1 | Switch takes the head payload at this edge |

## Verification
A buffer write and a head pop can fall on the same edge, and a refusal with its NACK can coincide with a pop that the switch issues in that cycle. The bench keeps `head_pop` high while it sends flits back to back, so stored payloads leave the buffer in the same cycles that new ones arrive or are refused; a scoreboard queue filled by the sender and drained by a monitor at every pop judges order and content, while the sender checks the NACK line one cycle after each flit. The full-buffer case is provoked with the pop held low, after which the pop is released and a resend is placed while the buffer is only partly drained.

// File: rtl/hop_ecc_pkg.sv
package hop_ecc_pkg;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_FIX    = 2'd1,
        MODE_RESEND = 2'd2,
        MODE_HYBRID = 2'd3
    } ecc_mode_e;

    typedef struct packed {
        logic discard;
        logic nack;
    } port_ctl_t;

    // Number of Hamming check bits needed to cover dw payload bits.
    function automatic int chk_bits(input int dw);
        for (int r = 1; r < 31; r++) begin
            if ((1 << r) >= dw + r + 1) return r;
        end
        return 31;
    endfunction

    // Hamming position of payload bit idx: the idx-th position (from 3) that
    // is not a power of two.
    function automatic int data_pos(input int idx);
        int n;
        n = 0;
        for (int p = 3; p < 4096; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) return p;
                n++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/hop_ecc_decoder.sv
module hop_ecc_decoder
    import hop_ecc_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int PAR_W  = chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W + 1
) (
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data_fix,
    output logic              err_any,
    output logic              err_uncorr
);

    localparam int LAST_POS = DATA_W + PAR_W;

    logic [PAR_W-1:0]  pos_tab [DATA_W];
    logic [DATA_W-1:0] raw;
    logic [PAR_W-1:0]  rx_chk;
    logic [PAR_W-1:0]  syn;
    logic              ovr;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_pos
        localparam int POS = data_pos(gi);
        assign pos_tab[gi] = PAR_W'(POS);
    end

    assign raw    = code[DATA_W-1:0];
    assign rx_chk = code[DATA_W +: PAR_W];
    assign ovr    = ^code;

    always_comb begin
        syn = rx_chk;
        for (int i = 0; i < DATA_W; i++) begin
            for (int k = 0; k < PAR_W; k++) begin
                if (pos_tab[i][k]) syn[k] = syn[k] ^ raw[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            data_fix[i] = raw[i] ^ (en && ovr && (syn == pos_tab[i]));
        end
    end

    assign err_any    = en && ((syn != '0) || ovr);
    assign err_uncorr = en && ((!ovr && (syn != '0)) || (ovr && (int'(syn) > LAST_POS)));

endmodule

// File: rtl/hop_ecc_fifo.sv
module hop_ecc_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (st_q.cnt == '0);
    assign full    = (int'(st_q.cnt) == DEPTH);
    assign rd_data = mem[st_q.rd_ptr];

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (rd_en) st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        case ({wr_en, rd_en})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wr_ptr] <= wr_data;
    end

endmodule

// File: rtl/hop_ecc_inport.sv
module hop_ecc_inport
    import hop_ecc_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 8,
    localparam int PAR_W  = chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              flit_valid,
    input  logic              flit_retry,
    input  logic [CODE_W-1:0] flit_code,
    input  logic              route_grant,
    output logic              nack,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    input  logic              head_pop
);

    port_ctl_t st_d, st_q;

    logic              buf_full;
    logic              buf_empty;
    logic              buf_wr;
    logic              buf_rd;
    logic [DATA_W-1:0] buf_wdata;
    logic              dec_en;
    logic [DATA_W-1:0] dec_fix;
    logic              dec_any;
    logic              dec_uncorr;
    logic              judged;
    logic              bad;
    logic              discard_q;

    // Decoding is only enabled when the buffer can take the flit.
    assign dec_en = flit_valid && !buf_full;

    hop_ecc_decoder #(.DATA_W(DATA_W)) u_dec (
        .en         (dec_en),
        .code       (flit_code),
        .data_fix   (dec_fix),
        .err_any    (dec_any),
        .err_uncorr (dec_uncorr)
    );

    always_comb begin
        judged = flit_valid && (!st_q.discard || flit_retry);
        case (ecc_mode_e'(cfg_mode))
            MODE_NONE:   begin bad = 1'b0;       buf_wdata = flit_code[DATA_W-1:0]; end
            MODE_FIX:    begin bad = 1'b0;       buf_wdata = dec_fix;               end
            MODE_RESEND: begin bad = dec_any;    buf_wdata = flit_code[DATA_W-1:0]; end
            default:     begin bad = dec_uncorr; buf_wdata = dec_fix;               end
        endcase
        buf_wr       = judged && !buf_full && route_grant && !bad;
        st_d.nack    = judged && !buf_wr;
        st_d.discard = st_d.nack || (st_q.discard && !judged);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_rd = head_pop && !buf_empty;

    hop_ecc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_data (buf_wdata),
        .rd_en   (buf_rd),
        .rd_data (head_data),
        .empty   (buf_empty),
        .full    (buf_full)
    );

    assign head_valid = !buf_empty;
    assign nack       = st_q.nack;
    assign discard_q  = st_q.discard;

endmodule

// File: rtl/hop_ecc_inport_chk.sv
module hop_ecc_inport_chk #(
    parameter int DEPTH = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       flit_valid,
    input logic       flit_retry,
    input logic       route_grant,
    input logic       nack,
    input logic       head_valid,
    input logic       head_pop,
    input logic       buf_full,
    input logic       buf_wr,
    input logic       discard_q,
    input logic       dec_any,
    input logic       dec_uncorr
);

    int  occ;
    logic judged;

    assign judged = flit_valid && (!discard_q || flit_retry);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ <= 0;
        else        occ <= occ + (buf_wr ? 1 : 0) - ((head_pop && head_valid) ? 1 : 0);
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!nack && !head_valid));

    p_fix_no_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !cfg_mode[1] && !buf_full && route_grant) |=> !nack);

    p_resend_detect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (judged && cfg_mode == 2'd2 && dec_any) |=> nack);

    p_hybrid_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (judged && cfg_mode == 2'd3 && dec_uncorr) |=> nack);

    p_hybrid_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (judged && cfg_mode == 2'd3 && !buf_full && route_grant && !dec_uncorr) |-> buf_wr);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH);

    p_full_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (judged && buf_full) |=> nack);

    p_port_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (judged && !route_grant) |=> nack);

    p_drop_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && discard_q && !flit_retry) |-> !buf_wr);

    p_drop_no_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && discard_q && !flit_retry) |=> !nack);

    p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> head_valid);

    p_nack_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nack |-> $past(flit_valid));

endmodule

bind hop_ecc_inport hop_ecc_inport_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .flit_valid  (flit_valid),
    .flit_retry  (flit_retry),
    .route_grant (route_grant),
    .nack        (nack),
    .head_valid  (head_valid),
    .head_pop    (head_pop),
    .buf_full    (buf_full),
    .buf_wr      (buf_wr),
    .discard_q   (discard_q),
    .dec_any     (dec_any),
    .dec_uncorr  (dec_uncorr)
);

// File: tb/hop_ecc_inport_tb.sv
module hop_ecc_inport_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        flit_valid = 1'b0;
    logic        flit_retry = 1'b0;
    logic [38:0] flit_code = '0;
    logic        route_grant = 1'b1;
    logic        nack;
    logic        head_valid;
    logic [31:0] head_data;
    logic        head_pop = 1'b1;

    int checks = 0;
    int fails  = 0;
    logic [31:0] sb_data [$];
    string       sb_tag  [$];

    always #4 clk = ~clk;

    hop_ecc_inport u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mode    (cfg_mode),
        .flit_valid  (flit_valid),
        .flit_retry  (flit_retry),
        .flit_code   (flit_code),
        .route_grant (route_grant),
        .nack        (nack),
        .head_valid  (head_valid),
        .head_data   (head_data),
        .head_pop    (head_pop)
    );

    // Independent encoder following the layout of R11.
    function automatic logic [38:0] enc(input logic [31:0] d);
        logic [5:0]  c;
        logic [37:0] w;
        int p;
        int i;
        c = '0;
        p = 3;
        i = 0;
        while (i < 32) begin
            if ((p & (p - 1)) != 0) begin
                for (int k = 0; k < 6; k++) if (p[k]) c[k] = c[k] ^ d[i];
                i++;
            end
            p++;
        end
        w = {c, d};
        return {^w, w};
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one flit per cycle, NACK judged in the following cycle.
    task automatic send(input logic [38:0] code, input logic retry, input logic acc,
                        input logic exp_nack, input logic [31:0] exp_data, input string req);
        flit_code  = code;
        flit_retry = retry;
        flit_valid = 1'b1;
        if (acc) begin
            sb_data.push_back(exp_data);
            sb_tag.push_back(req);
        end
        @(negedge clk);
        flit_valid = 1'b0;
        flit_retry = 1'b0;
        #1;
        check(nack == exp_nack, {req, " nack"}, 32'(nack), 32'(exp_nack));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Monitor: scoreboard comparison at every pop.
    always @(negedge clk) begin
        #2;
        if (rst_n && head_valid && head_pop) begin
            if (sb_data.size() == 0) begin
                check(1'b0, "R9 unexpected pop", head_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = sb_data.pop_front();
                t = sb_tag.pop_front();
                check(head_data == e, {t, " data (R9 order)"}, head_data, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(2);
        check(nack == 1'b0 && head_valid == 1'b0, "R1 during reset", {nack, head_valid}, 0);
        rst_n = 1'b1;
        idle(1);
        check(nack == 1'b0 && head_valid == 1'b0, "R1 after reset", {nack, head_valid}, 0);

        // R2: no error control
        cfg_mode = 2'd0;
        d = 32'hA5A5_0F0F;
        send(enc(d) ^ (39'd1 << 3) ^ (39'd1 << 35), 0, 1, 0, d ^ 32'h8, "R2 raw stored");
        d = 32'h1234_5678;
        send(enc(d), 0, 1, 0, d, "R2 clean");

        // R3: correct only
        cfg_mode = 2'd1;
        d = 32'hDEAD_BEEF;
        send(enc(d) ^ (39'd1 << 5), 0, 1, 0, d, "R3 data bit fixed");
        d = 32'h0000_FFFF;
        send(enc(d) ^ (39'd1 << 34), 0, 1, 0, d, "R3 check bit fixed");
        d = 32'h8000_0001;
        send(enc(d) ^ 39'd3, 0, 1, 0, d ^ 32'd3, "R3 double kept");

        // R4 and R8: detect and resend
        cfg_mode = 2'd2;
        d = 32'hCAFE_0001;
        send(enc(d), 0, 1, 0, d, "R4 clean");
        send(enc(32'h1111_2222) ^ (39'd1 << 17), 0, 0, 1, 0, "R4 single refused");
        send(enc(32'h3333_4444), 0, 0, 0, 0, "R8 dropped silently");
        send(enc(32'h5555_6666) ^ (39'd1 << 1) ^ (39'd1 << 30), 1, 0, 1, 0, "R4 double refused");
        send(enc(32'h7777_8888), 0, 0, 0, 0, "R8 dropped again");
        d = 32'h1111_2222;
        send(enc(d), 1, 1, 0, d, "R8 resend accepted");
        d = 32'h9999_AAAA;
        send(enc(d), 0, 1, 0, d, "R8 normal after resend");

        // R5: hybrid
        cfg_mode = 2'd3;
        d = 32'h0BAD_F00D;
        send(enc(d) ^ (39'd1 << 31), 0, 1, 0, d, "R5 single fixed");
        d = 32'h7E57_0000;
        send(enc(d) ^ (39'd1 << 38), 0, 1, 0, d, "R5 parity bit fixed");
        send(enc(32'h2468_ACE0) ^ (39'd1 << 8) ^ (39'd1 << 9), 0, 0, 1, 0, "R5 double refused");
        d = 32'h2468_ACE0;
        send(enc(d) ^ (39'd1 << 12), 1, 1, 0, d, "R5 resend single fixed");

        // R7: output port not granted
        route_grant = 1'b0;
        send(enc(32'h1357_9BDF), 0, 0, 1, 0, "R7 no grant refused");
        route_grant = 1'b1;
        d = 32'h1357_9BDF;
        send(enc(d), 1, 1, 0, d, "R7 resend granted");

        // R6: full buffer
        idle(4);
        check(head_valid == 1'b0, "R9 drained", 32'(head_valid), 0);
        cfg_mode = 2'd0;
        head_pop = 1'b0;
        for (int i = 0; i < 8; i++) begin
            send(enc(32'hF000_0000 + 32'(i)), 0, 1, 0, 32'hF000_0000 + 32'(i), "R6 fill");
        end
        send(enc(32'hF000_0008), 0, 0, 1, 0, "R6 full refused");
        check(head_valid == 1'b1 && head_data == 32'hF000_0000, "R6 head kept", head_data, 32'hF000_0000);
        head_pop = 1'b1;
        idle(2);
        send(enc(32'hF000_0008), 1, 1, 0, 32'hF000_0008, "R6 resend after drain");

        // R9 and R10: back-to-back writes while popping
        cfg_mode = 2'd2;
        for (int i = 0; i < 6; i++) begin
            d = 32'hB000_0000 + 32'(i * 7);
            send(enc(d), 0, 1, 0, d, "R9 write with pop");
        end
        send(enc(32'hB0FF_0000) ^ (39'd1 << 20), 0, 0, 1, 0, "R10 refuse while popping");
        d = 32'hB0FF_0000;
        send(enc(d), 1, 1, 0, d, "R10 resend");
        idle(1);
        check(nack == 1'b0, "R10 single pulse", 32'(nack), 0);

        idle(14);
        check(sb_data.size() == 0, "R9 all delivered", 32'(sb_data.size()), 0);
        check(head_valid == 1'b0, "R9 empty at end", 32'(head_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule